// File: doc/BRIEF.md
# FIFO Event and Interrupt Controller

This block watches a 32-entry FIFO used by an infrared serial link controller and turns what happens there into interrupt events. It keeps its own count of FIFO entries from the push and pop strobes, and compares that count against a receive threshold and a transmit threshold. Each threshold is chosen by a 4-bit code. A timer raises a receive timeout when data sits unread for too long. The timer counts baud ticks in the two slow serial modes and clock cycles in the two fast modes. Error pulses from the framers are caught in the same event register.

Each event bit has its own clear rule. Error and end-of-frame bits, and the transmit-empty bit, clear when the event register is read. The two threshold bits follow their level condition. The receive bit stays up while the timeout flag stands, and that flag clears on a FIFO read. An 8-bit enable register masks the events onto an active-low interrupt line.

The block carries no data: push and pop are plain strobes from the FIFO's own handshake, so there is no valid/ready channel and no back-pressure at this edge. All pins are plain control and status.

Top module: `irq_event_ctrl`

## Requirements
- R1: After reset the event register, the enable register, the level and the timeout flag are 0, `irq_n` is 1, and both threshold codes are 0111 (14 bytes).
- R2: A push is accepted when the level is below 32, or when a pop is accepted in the same cycle. A pop is accepted when the level is nonzero. The level rises by one for each accepted push and falls by one for each accepted pop, so a push and a pop in the same cycle leave it unchanged. It stays within 0 to 32.
- R3: A push at level 32 without a pop is not accepted: the level stays at 32 and `events[1]` (overrun) is set at the same clock edge.
- R4: Threshold code 0 means 1 byte and code n≥1 means 2n bytes. `thr_wdata[7:4]` is the receive code and `thr_wdata[3:0]` is the transmit code, both loaded on `thr_we`. One clock after the condition, `events[5]` equals (receive mode and level ≥ receive threshold) OR the timeout flag, and `events[6]` equals (transmit mode and level < transmit threshold).
- R5: In modes 00 and 01 (slow serial), in receive mode, the timeout flag `rx_timeout` is set at the 32nd `baud_tick` after the last accepted push, provided no pop has been accepted since.
- R6: In modes 10 and 11 (fast), the same timeout fires LONG_CYC clock cycles after the last accepted push. `baud_tick` is ignored in these modes.
- R7: The timeout flag clears on an accepted pop. A push restarts the timeout count but does not clear a standing flag. A pop stops the count.
- R8: Bits 0 (framing/abort/encode error, `err_sym`), 1, 2 (`err_crc`), 3 (`err_len`), 4 (`eof_seen`) and 7 are set by their condition and hold until an `evt_rd` strobe. If a bit's condition is present in the same cycle as `evt_rd`, that bit stays set.
- R9: In mode 00, `err_crc` and `eof_seen` are ignored. In the other three modes they set bits 2 and 4.
- R10: `events[7]` is set when the block is in transmit mode, the level is 0 and `tsr_empty` is high.
- R11: When `tx_en` and `rx_en` are both high, the block is in receive mode. Transmit mode is `tx_en` with `rx_en` low.
- R12: `en_we` loads `en_wdata`. `irq_n` is low exactly while (events AND enables) is nonzero, following the registers with no added delay. Events are recorded whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 slow serial, 01 framed slow serial, 10 medium, 11 fast |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable (takes priority) |
| fifo_push | input | 1 | FIFO write strobe |
| fifo_pop | input | 1 | FIFO read strobe |
| tsr_empty | input | 1 | Transmit shift register is empty |
| baud_tick | input | 1 | One pulse per bit time |
| err_sym | input | 1 | Framing, abort or encode error pulse |
| err_crc | input | 1 | CRC error pulse |
| err_len | input | 1 | Maximum-length error pulse |
| eof_seen | input | 1 | End-of-frame byte reached FIFO bottom |
| evt_rd | input | 1 | Event register read strobe |
| en_we | input | 1 | Enable register write |
| en_wdata | input | 8 | Enable register data |
| thr_we | input | 1 | Threshold codes write |
| thr_wdata | input | 8 | [7:4] receive code, [3:0] transmit code |
| level | output | LVL_W (6) | FIFO entry count |
| events | output | 8 | Event register |
| rx_timeout | output | 1 | Receive timeout flag |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Two pairs of functions can meet in one clock. The first is a read-clear strobe arriving in the same cycle as a fresh error pulse or a still-true transmit-empty condition. That case is driven directly, and the check confirms that the bit stays set while its neighbours clear. The second is a push and a pop together on a full FIFO, which must be accepted without an overrun and leave the level at 32. A behavioural model in the bench follows every strobe and is compared with all outputs on every clock. Directed checks also pin the exact cycle at which each threshold and timeout boundary is crossed.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

  typedef enum logic [1:0] {
    MODE_SIR  = 2'd0,
    MODE_XSIR = 2'd1,
    MODE_MIR  = 2'd2,
    MODE_FIR  = 2'd3
  } ir_mode_e;

  localparam int EV_SYM = 0;
  localparam int EV_OVR = 1;
  localparam int EV_CRC = 2;
  localparam int EV_LEN = 3;
  localparam int EV_EOF = 4;
  localparam int EV_RXH = 5;
  localparam int EV_TXL = 6;
  localparam int EV_TXE = 7;

  // bits that hold until the event register is read
  localparam logic [7:0] RD_CLR_MASK = 8'b1001_1111;

  // 4-bit threshold code to byte count: 0 -> 1, n -> 2n
  function automatic int thr_bytes(input logic [3:0] code);
    return (code == 4'd0) ? 1 : 2 * int'(code);
  endfunction

endpackage

// File: rtl/fifo_level_track.sv
module fifo_level_track #(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             overrun
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] lvl_q;

  always_comb begin
    pop_ok  = pop && (lvl_q != '0);
    push_ok = push && ((lvl_q != FULL) || pop_ok);
    overrun = push && !push_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (push_ok && !pop_ok) begin
      lvl_q <= lvl_q + 1'b1;
    end else if (pop_ok && !push_ok) begin
      lvl_q <= lvl_q - 1'b1;
    end
  end

  assign level = lvl_q;

  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n) lvl_q <= FULL); // R2
  AST_OVR_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> (lvl_q == $past(lvl_q))); // R3

endmodule

// File: rtl/rx_timeout_timer.sv
module rx_timeout_timer #(
  parameter int SIR_BITS = 32,
  parameter int LONG_CYC = 3336000,
  parameter int CNT_W    = $clog2(LONG_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_ok,
  input  logic pop_ok,
  input  logic rx_mode,
  input  logic short_rule,
  input  logic baud_tick,
  output logic to_flag
);
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step;
  logic [CNT_W:0]   limit;
  logic             fire;

  always_comb begin
    step  = short_rule ? baud_tick : 1'b1;
    limit = short_rule ? (CNT_W+1)'(SIR_BITS) : (CNT_W+1)'(LONG_CYC);
    fire  = armed_q && rx_mode && step && !push_ok && !pop_ok &&
            (({1'b0, cnt_q} + 1'b1) >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (push_ok) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (pop_ok || fire) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q && rx_mode && step) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      to_flag <= 1'b0;
    else if (fire)   to_flag <= 1'b1;
    else if (pop_ok) to_flag <= 1'b0;
  end

  AST_TO_CLEARS_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> !to_flag); // R7
  AST_TO_ONLY_RX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag) |-> $past(rx_mode)); // R5

endmodule

// File: rtl/event_latch.sv
module event_latch
  import irq_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ev_in,
  input  logic       evt_rd,
  input  logic       en_we,
  input  logic [7:0] en_wdata,
  output logic [7:0] evt_q,
  output logic       irq_n
);
  logic [7:0] en_q;

  for (genvar i = 0; i < 8; i++) begin : g_bit
    if (RD_CLR_MASK[i]) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q[i] <= 1'b0;
        else        evt_q[i] <= ev_in[i] | (evt_q[i] & ~evt_rd);
      end
    end else begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q[i] <= 1'b0;
        else        evt_q[i] <= ev_in[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

  assign irq_n = ~|(evt_q & en_q);

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && ((ev_in & RD_CLR_MASK) == 8'd0)) |=> ((evt_q & RD_CLR_MASK) == 8'd0)); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_in & RD_CLR_MASK) != 8'd0) |=>
      ((evt_q & $past(ev_in) & RD_CLR_MASK) == ($past(ev_in) & RD_CLR_MASK))); // R8

endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irq_evt_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int SIR_BITS = 32,
  parameter int LONG_CYC = 3336000,
  parameter int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             fifo_push,
  input  logic             fifo_pop,
  input  logic             tsr_empty,
  input  logic             baud_tick,
  input  logic             err_sym,
  input  logic             err_crc,
  input  logic             err_len,
  input  logic             eof_seen,
  input  logic             evt_rd,
  input  logic             en_we,
  input  logic [7:0]       en_wdata,
  input  logic             thr_we,
  input  logic [7:0]       thr_wdata,
  output logic [LVL_W-1:0] level,
  output logic [7:0]       events,
  output logic             rx_timeout,
  output logic             irq_n
);
  localparam int LIM_MAX = (LONG_CYC > SIR_BITS) ? LONG_CYC : SIR_BITS;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  ir_mode_e   mode_e;
  logic       rx_mode, tx_mode, short_rule, framed;
  logic       push_ok, pop_ok, overrun;
  logic [3:0] rx_code_q, tx_code_q;
  logic       rx_hit, tx_low;
  logic [7:0] ev_in;

  assign mode_e     = ir_mode_e'(mode);
  assign rx_mode    = rx_en;
  assign tx_mode    = tx_en && !rx_en;
  assign short_rule = (mode_e == MODE_SIR) || (mode_e == MODE_XSIR);
  assign framed     = (mode_e != MODE_SIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_code_q <= 4'b0111;
      tx_code_q <= 4'b0111;
    end else if (thr_we) begin
      rx_code_q <= thr_wdata[7:4];
      tx_code_q <= thr_wdata[3:0];
    end
  end

  fifo_level_track #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .pop(fifo_pop),
    .level(level), .push_ok(push_ok), .pop_ok(pop_ok), .overrun(overrun)
  );

  rx_timeout_timer #(.SIR_BITS(SIR_BITS), .LONG_CYC(LONG_CYC), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop_ok(pop_ok),
    .rx_mode(rx_mode), .short_rule(short_rule), .baud_tick(baud_tick),
    .to_flag(rx_timeout)
  );

  always_comb begin
    rx_hit = rx_mode && (int'(level) >= thr_bytes(rx_code_q));
    tx_low = tx_mode && (int'(level) <  thr_bytes(tx_code_q));
    ev_in          = '0;
    ev_in[EV_SYM]  = err_sym;
    ev_in[EV_OVR]  = overrun;
    ev_in[EV_CRC]  = err_crc && framed;
    ev_in[EV_LEN]  = err_len;
    ev_in[EV_EOF]  = eof_seen && framed;
    ev_in[EV_RXH]  = rx_hit || rx_timeout;
    ev_in[EV_TXL]  = tx_low;
    ev_in[EV_TXE]  = tx_mode && (level == '0) && tsr_empty;
  end

  event_latch u_events (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .evt_rd(evt_rd),
    .en_we(en_we), .en_wdata(en_wdata), .evt_q(events), .irq_n(irq_n)
  );

  AST_TXL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_low |=> events[EV_TXL]); // R4
  AST_TO_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_timeout) |-> (level != '0)); // R5

endmodule

// File: tb/test_irq_event_ctrl.sv
module test_irq_event_ctrl;
  localparam int LONG = 200;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [1:0] mode;
  logic       tx_en, rx_en, fifo_push, fifo_pop, tsr_empty, baud_tick;
  logic       err_sym, err_crc, err_len, eof_seen, evt_rd, en_we, thr_we;
  logic [7:0] en_wdata, thr_wdata;
  logic [5:0] level;
  logic [7:0] events;
  logic       rx_timeout, irq_n;

  int checks = 0;
  int errors = 0;

  irq_event_ctrl #(.DEPTH(32), .SIR_BITS(32), .LONG_CYC(LONG)) i_irq_event_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tx_en(tx_en), .rx_en(rx_en),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop), .tsr_empty(tsr_empty),
    .baud_tick(baud_tick), .err_sym(err_sym), .err_crc(err_crc),
    .err_len(err_len), .eof_seen(eof_seen), .evt_rd(evt_rd),
    .en_we(en_we), .en_wdata(en_wdata), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .level(level), .events(events), .rx_timeout(rx_timeout), .irq_n(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int thr_of(input int c);
    return (c == 0) ? 1 : 2 * c;
  endfunction

  function automatic string tag_of(input int b);
    case (b)
      1:       return "R3 overrun event";
      2, 4:    return "R9 crc/eof event";
      5, 6:    return "R4 threshold event";
      7:       return "R10 tx empty event";
      default: return "R8 read-clear event";
    endcase
  endfunction

  // behavioural reference model
  int         m_lvl = 0, m_cnt = 0, m_rxc = 7, m_txc = 7;
  bit         m_to = 0, m_arm = 0;
  logic [7:0] m_evt = '0, m_en = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl = 0; m_cnt = 0; m_rxc = 7; m_txc = 7;
      m_to = 0; m_arm = 0; m_evt = '0; m_en = '0;
    end else begin
      bit rxm, txm, popk, pushk, shortr, stp, fire, framed;
      int lim;
      logic [7:0] n;
      rxm    = rx_en;
      txm    = tx_en && !rx_en;
      popk   = fifo_pop && (m_lvl > 0);
      pushk  = fifo_push && ((m_lvl < 32) || popk);
      shortr = (mode < 2);
      framed = (mode != 0);
      lim    = shortr ? 32 : LONG;
      stp    = shortr ? baud_tick : 1'b1;
      fire   = m_arm && rxm && stp && !pushk && !popk && (m_cnt + 1 >= lim);
      n[0] = err_sym || (m_evt[0] && !evt_rd);
      n[1] = (fifo_push && !pushk) || (m_evt[1] && !evt_rd);
      n[2] = (err_crc && framed) || (m_evt[2] && !evt_rd);
      n[3] = err_len || (m_evt[3] && !evt_rd);
      n[4] = (eof_seen && framed) || (m_evt[4] && !evt_rd);
      n[5] = (rxm && m_lvl >= thr_of(m_rxc)) || m_to;
      n[6] = txm && (m_lvl < thr_of(m_txc));
      n[7] = (txm && m_lvl == 0 && tsr_empty) || (m_evt[7] && !evt_rd);
      m_evt = n;
      if (fire) m_to = 1; else if (popk) m_to = 0;
      if (pushk) begin m_arm = 1; m_cnt = 0; end
      else if (popk || fire) begin m_arm = 0; m_cnt = 0; end
      else if (m_arm && rxm && stp) m_cnt++;
      m_lvl = m_lvl + int'(pushk) - int'(popk);
      if (thr_we) begin m_rxc = int'(thr_wdata[7:4]); m_txc = int'(thr_wdata[3:0]); end
      if (en_we) m_en = en_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 level vs model", int'(level), m_lvl);
      for (int b = 0; b < 8; b++) chk(tag_of(b), int'(events[b]), int'(m_evt[b]));
      chk("R5 timeout flag vs model", int'(rx_timeout), int'(m_to));
      chk("R12 irq_n vs model", int'(irq_n), int'(~|(m_evt & m_en)));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int n);
    repeat (n) begin fifo_push = 1'b1; @(negedge clk); fifo_push = 1'b0; end
  endtask

  task automatic pop(input int n);
    repeat (n) begin fifo_pop = 1'b1; @(negedge clk); fifo_pop = 1'b0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; mode = 2'b00; tx_en = 0; rx_en = 0; fifo_push = 0; fifo_pop = 0;
    tsr_empty = 0; baud_tick = 0; err_sym = 0; err_crc = 0; err_len = 0;
    eof_seen = 0; evt_rd = 0; en_we = 0; thr_we = 0; en_wdata = '0; thr_wdata = '0;
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 reset events", int'(events), 0);
    chk("R1 reset level", int'(level), 0);
    chk("R1 reset irq_n", int'(irq_n), 1);
    chk("R1 reset timeout", int'(rx_timeout), 0);

    // transmit threshold at its reset code (14 bytes)
    tx_en = 1;
    push(13); step(1);
    chk("R1 tx low below 14", int'(events[6]), 1);
    push(1); step(1);
    chk("R4 tx low cleared at 14", int'(events[6]), 0);
    fifo_push = 1; fifo_pop = 1; step(1); fifo_push = 0; fifo_pop = 0;
    chk("R2 push and pop together", int'(level), 14);
    pop(14); pop(1);
    chk("R2 pop on empty ignored", int'(level), 0);

    // transmit empty and read-clear race
    tsr_empty = 1; step(1);
    chk("R10 tx empty set", int'(events[7]), 1);
    evt_rd = 1; step(1); evt_rd = 0;
    chk("R8 read with condition still true", int'(events[7]), 1);
    tsr_empty = 0; evt_rd = 1; step(1); evt_rd = 0;
    chk("R8 tx empty cleared on read", int'(events[7]), 0);

    // both enables: receive mode
    rx_en = 1; tsr_empty = 1; step(2);
    chk("R11 no tx empty in rx priority", int'(events[7]), 0);
    chk("R11 no tx low in rx priority", int'(events[6]), 0);
    tsr_empty = 0; tx_en = 0;

    // receive threshold code 15 -> 30 bytes, code 0 -> 1 byte
    thr_we = 1; thr_wdata = 8'hF0; step(1); thr_we = 0;
    push(29); step(1);
    chk("R4 rx high at 29 of 30", int'(events[5]), 0);
    push(1); step(1);
    chk("R4 rx high at 30", int'(events[5]), 1);
    pop(1); step(1);
    chk("R4 rx high drops below", int'(events[5]), 0);
    thr_we = 1; thr_wdata = 8'h00; step(1); thr_we = 0; step(1);
    chk("R4 rx code 0 means 1 byte", int'(events[5]), 1);
    push(3);
    chk("R2 level full", int'(level), 32);
    push(1);
    chk("R3 overrun keeps level", int'(level), 32);
    chk("R3 overrun event", int'(events[1]), 1);
    fifo_push = 1; fifo_pop = 1; step(1); fifo_push = 0; fifo_pop = 0;
    chk("R2 push and pop at full", int'(level), 32);
    pop(32); step(1);
    chk("R2 drained", int'(level), 0);
    chk("R4 rx high clear when empty", int'(events[5]), 0);

    // slow-mode timeout: 32 baud ticks
    thr_we = 1; thr_wdata = 8'hF0; step(1); thr_we = 0;
    push(1);
    baud_tick = 1; step(31);
    chk("R5 no timeout after 31 ticks", int'(rx_timeout), 0);
    step(1); baud_tick = 0;
    chk("R5 timeout at 32 ticks", int'(rx_timeout), 1);
    step(1);
    chk("R4 rx event from timeout", int'(events[5]), 1);
    push(1);
    chk("R7 push keeps timeout flag", int'(rx_timeout), 1);
    pop(1);
    chk("R7 pop clears timeout", int'(rx_timeout), 0);
    step(1);
    chk("R7 rx event clears after read", int'(events[5]), 0);
    pop(1);

    // fast-mode timeout: LONG clock cycles
    mode = 2'b10;
    push(1);
    baud_tick = 1; step(LONG - 1); baud_tick = 0;
    chk("R6 no timeout before limit", int'(rx_timeout), 0);
    step(1);
    chk("R6 timeout at limit", int'(rx_timeout), 1);
    pop(1);
    chk("R7 timeout cleared", int'(rx_timeout), 0);
    rx_en = 0;

    // error events and clear-on-read
    mode = 2'b00;
    err_crc = 1; eof_seen = 1; step(1); err_crc = 0; eof_seen = 0;
    chk("R9 crc ignored in mode 00", int'(events[2]), 0);
    chk("R9 eof ignored in mode 00", int'(events[4]), 0);
    mode = 2'b01;
    err_crc = 1; eof_seen = 1; step(1); err_crc = 0; eof_seen = 0;
    chk("R9 crc taken in mode 01", int'(events[2]), 1);
    chk("R9 eof taken in mode 01", int'(events[4]), 1);
    err_sym = 1; err_len = 1; step(1); err_sym = 0; err_len = 0;
    chk("R8 symbol error set", int'(events[0]), 1);
    chk("R8 length error set", int'(events[3]), 1);
    evt_rd = 1; err_len = 1; step(1); evt_rd = 0; err_len = 0;
    chk("R8 read with new length error", int'(events), 8'h08);
    evt_rd = 1; step(1); evt_rd = 0;
    chk("R8 read clears all", int'(events), 0);

    // interrupt masking
    en_we = 1; en_wdata = 8'h08; step(1); en_we = 0;
    err_sym = 1; step(1); err_sym = 0;
    chk("R12 masked event recorded", int'(events[0]), 1);
    chk("R12 masked event no irq", int'(irq_n), 1);
    err_len = 1; step(1); err_len = 0;
    chk("R12 enabled event irq", int'(irq_n), 0);
    evt_rd = 1; step(1); evt_rd = 0;
    chk("R12 irq released after read", int'(irq_n), 1);

    step(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule